// File: doc/BRIEF.md
# Retry-Handshake Request Port

This block joins one requester to a shared resource that serves a single request at a time. It never queues. When it cannot take a request it refuses it on the spot and notes that the requester is owed a wake-up. Once the resource is free again and no response is waiting, it sends that wake-up as a one-cycle retry notice. Requests go downstream in the same cycle they are offered, tagged with the port's fixed index. Responses come back carrying an index, and only responses that carry this port's index are delivered.

If the requester turns a response away, the port keeps it in a single-entry hold slot. It offers the response again only when the requester raises its resume signal. While the slot is occupied, every new request is refused, so the resource can never produce a second response for this port that the slot would have to absorb. Several such ports sit in front of one resource. Arbitration between them and the storage behind the resource belong to other blocks.

Top module: `rport_retry_port`

## Requirements
- R1: After a synchronous active-low reset with all inputs low, `up_retry`, `up_rsp_valid` and `dn_req_valid` are 0, and the port is owed no retry and holds no response.
- R2: When no retry is owed and the hold slot is empty, a request is presented downstream in the same cycle with unchanged data and `dn_req_port` equal to `PORT_ID`. `up_req_accept` equals `dn_req_ready` in that cycle.
- R3: A request that is offered but not accepted leaves the port owing a retry. This holds for a downstream refusal too, and the next request is then refused even if the resource is ready.
- R4: While a retry is owed or the hold slot is full, `dn_req_valid` and `up_req_accept` stay 0 for any request.
- R5: A response is delivered upstream in its own cycle, with `up_rsp_data` equal to its data, only if `dn_rsp_port` equals `PORT_ID`. A response with any other index leaves `up_rsp_valid` at 0 and fills no slot.
- R6: A response offered while `up_rsp_ready` is 0 is held. `up_rsp_valid` then stays 0 until `up_rsp_resume` is 1. In that cycle the held data is shown, and the response is kept again if `up_rsp_ready` is 0.
- R7: On the edge that ends a cycle in which a retry is owed, the slot will be empty after that edge, and either `res_free` is 1 or a held response is being taken, the owed flag clears and `up_retry` is 1 for one cycle.
- R8: No retry notice is issued while a response stays held, even when `res_free` is 1. Taking the held response is itself enough to issue the owed notice.
- R9: `res_free` with no retry owed produces no notice.
- R10: A request offered in the cycle where `up_retry` is 1 is judged by the normal rules, and is accepted when the resource is ready.
- R11: A matching response must not arrive while the hold slot is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req_valid | input | 1 | Requester offers a request |
| up_req_data | input | REQ_W | Request payload |
| up_req_accept | output | 1 | Request taken this cycle (0 means refused) |
| up_retry | output | 1 | One-cycle notice that a refused requester may try again |
| up_rsp_valid | output | 1 | Response offered to the requester |
| up_rsp_data | output | RSP_W | Response payload |
| up_rsp_ready | input | 1 | Requester takes the offered response |
| up_rsp_resume | input | 1 | Requester can take a held response again |
| dn_req_valid | output | 1 | Request forwarded to the resource |
| dn_req_data | output | REQ_W | Forwarded payload |
| dn_req_port | output | ID_W | Index of this port attached to the request |
| dn_req_ready | input | 1 | Resource takes the forwarded request |
| dn_rsp_valid | input | 1 | Resource returns a response |
| dn_rsp_data | input | RSP_W | Response payload from the resource |
| dn_rsp_port | input | ID_W | Index the response is routed to |
| res_free | input | 1 | Resource has just become free |

## Verification
The hardest state to reach is a retry that is owed while a response sits in the hold slot. In that state a `res_free` pulse must be swallowed, and the notice must appear only when the held response is finally taken. The directed part gets there by first refusing a request downstream and then returning a matching response with `up_rsp_ready` low. It then pulses `res_free` and resumes twice, first refusing the response and then taking it. The random part draws requests, readiness, resumes, foreign-index responses and `res_free` from a seeded generator. Matching responses are drawn only while the bench's model slot is empty, so these overlaps recur many times.

// File: rtl/rport_pkg.sv
// Shared types for the retry-handshake request port.
package rport_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/rport_hold_slot.sv
// One-entry response hold slot.
// Passes a live response straight to the requester. If the requester refuses
// it, the response is captured and re-offered only while resume is high.
// Assumes no live response arrives while the slot is full.
module rport_hold_slot #(
    parameter int RSP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live_valid,
    input  logic [RSP_W-1:0] live_data,
    input  logic             up_ready,
    input  logic             up_resume,
    output logic             up_valid,
    output logic [RSP_W-1:0] up_data,
    output logic             slot_full,
    output logic             slot_empty_next,
    output logic             slot_release
);
    import rport_pkg::*;

    slot_state_e      state_q, state_d;
    logic [RSP_W-1:0] data_q;
    logic             capture;

    // Select what the requester sees and work out the next slot state.
    always_comb begin
        slot_full       = (state_q == SLOT_FULL);
        up_valid        = live_valid | (slot_full & up_resume);
        up_data         = slot_full ? data_q : live_data;
        slot_release    = slot_full & up_resume & up_ready;
        capture         = live_valid & ~slot_full & ~up_ready;
        state_d         = state_q;
        if (capture)           state_d = SLOT_FULL;
        else if (slot_release) state_d = SLOT_EMPTY;
        slot_empty_next = (state_d == SLOT_EMPTY);
    end

    // Slot state and stored payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) data_q <= live_data;
        end
    end

    AST_HOLD_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_full |-> !live_valid); // R11
    AST_HOLD_FROM_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_full) |-> $past(up_valid && !up_ready)); // R6
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_full && !(up_resume && up_ready)) |=> slot_full); // R6
endmodule

// File: rtl/rport_retry_tracker.sv
// Owed-retry bookkeeping.
// Records every refusal and issues a one-cycle notice once the resource is
// free (or a held response drains) and the hold slot will be empty.
// Issuing the notice also answers a refusal made in that same cycle.
module rport_retry_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic refuse,
    input  logic res_free,
    input  logic slot_release,
    input  logic slot_empty_next,
    output logic owed,
    output logic notice
);
    logic issue;

    // Decide whether the owed notice goes out on this edge.
    always_comb begin
        issue = owed & slot_empty_next & (res_free | slot_release);
    end

    // Owed flag and registered notice pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed   <= 1'b0;
            notice <= 1'b0;
        end else begin
            notice <= issue;
            owed   <= issue ? 1'b0 : (owed | refuse);
        end
    end

    AST_RETRY_CLEARS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        notice |-> !owed); // R7
    AST_REFUSAL_OWES: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> (owed || notice)); // R3
    AST_NOTICE_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        notice |-> $past(res_free || slot_release)); // R7
endmodule

// File: rtl/rport_retry_port.sv
// Retry-handshake request port (top).
// Forwards requests to a shared blocking resource without queuing, refusing
// them while a retry is owed or a response is held. Tags requests with
// PORT_ID and delivers only responses routed back to that index.
// Assumes the resource produces at most one response per accepted request.
module rport_retry_port #(
    parameter int REQ_W   = 16,
    parameter int RSP_W   = 16,
    parameter int ID_W    = 2,
    parameter int PORT_ID = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req_valid,
    input  logic [REQ_W-1:0] up_req_data,
    output logic             up_req_accept,
    output logic             up_retry,
    output logic             up_rsp_valid,
    output logic [RSP_W-1:0] up_rsp_data,
    input  logic             up_rsp_ready,
    input  logic             up_rsp_resume,
    output logic             dn_req_valid,
    output logic [REQ_W-1:0] dn_req_data,
    output logic [ID_W-1:0]  dn_req_port,
    input  logic             dn_req_ready,
    input  logic             dn_rsp_valid,
    input  logic [RSP_W-1:0] dn_rsp_data,
    input  logic [ID_W-1:0]  dn_rsp_port,
    input  logic             res_free
);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(PORT_ID);

    logic owed, slot_full, slot_empty_next, slot_release, live_valid, refuse;

    // Gate and tag requests, judge acceptance, and filter responses by index.
    always_comb begin
        dn_req_valid  = up_req_valid & ~owed & ~slot_full;
        dn_req_data   = up_req_data;
        dn_req_port   = MY_ID;
        up_req_accept = dn_req_valid & dn_req_ready;
        refuse        = up_req_valid & ~up_req_accept;
        live_valid    = dn_rsp_valid & (dn_rsp_port == MY_ID);
    end

    rport_hold_slot #(.RSP_W(RSP_W)) u_slot (
        .clk             (clk),
        .rst_n           (rst_n),
        .live_valid      (live_valid),
        .live_data       (dn_rsp_data),
        .up_ready        (up_rsp_ready),
        .up_resume       (up_rsp_resume),
        .up_valid        (up_rsp_valid),
        .up_data         (up_rsp_data),
        .slot_full       (slot_full),
        .slot_empty_next (slot_empty_next),
        .slot_release    (slot_release)
    );

    rport_retry_tracker u_track (
        .clk             (clk),
        .rst_n           (rst_n),
        .refuse          (refuse),
        .res_free        (res_free),
        .slot_release    (slot_release),
        .slot_empty_next (slot_empty_next),
        .owed            (owed),
        .notice          (up_retry)
    );

    AST_ACCEPT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_accept |-> (dn_req_valid && dn_req_ready)); // R2
    AST_NOTICE_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        up_retry |-> !slot_full); // R8
    AST_FOREIGN_RSP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_full && dn_rsp_valid && dn_rsp_port != MY_ID) |-> !up_rsp_valid); // R5
endmodule

// File: tb/rport_retry_port_test.sv
module rport_retry_port_test;
    localparam int PERIOD = 10;
    localparam int REQ_W = 16, RSP_W = 16, ID_W = 2, PORT_ID = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic up_req_valid = 0, up_rsp_ready = 0, up_rsp_resume = 0;
    logic dn_req_ready = 0, dn_rsp_valid = 0, res_free = 0;
    logic [REQ_W-1:0] up_req_data = '0;
    logic [RSP_W-1:0] dn_rsp_data = '0;
    logic [ID_W-1:0]  dn_rsp_port = '0;
    logic up_req_accept, up_retry, up_rsp_valid, dn_req_valid;
    logic [RSP_W-1:0] up_rsp_data;
    logic [REQ_W-1:0] dn_req_data;
    logic [ID_W-1:0]  dn_req_port;

    int errors = 0, checks = 0;

    // Reference model state
    logic m_owed = 0, m_full = 0, m_retry = 0;
    logic [RSP_W-1:0] m_data = '0;
    logic n_owed, n_full, n_retry;
    logic [RSP_W-1:0] n_data;

    rport_retry_port #(.REQ_W(REQ_W), .RSP_W(RSP_W), .ID_W(ID_W), .PORT_ID(PORT_ID)) uut (
        .clk(clk), .rst_n(rst_n),
        .up_req_valid(up_req_valid), .up_req_data(up_req_data), .up_req_accept(up_req_accept),
        .up_retry(up_retry), .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data),
        .up_rsp_ready(up_rsp_ready), .up_rsp_resume(up_rsp_resume),
        .dn_req_valid(dn_req_valid), .dn_req_data(dn_req_data), .dn_req_port(dn_req_port),
        .dn_req_ready(dn_req_ready), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data),
        .dn_rsp_port(dn_rsp_port), .res_free(res_free)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_fwd();
        return up_req_valid && !m_owed && !m_full;
    endfunction

    // Mid-cycle: compare outputs against the model and compute its next state.
    task automatic settle();
        logic fwd, acc, live, rel, wake;
        #4;
        fwd  = exp_fwd();
        acc  = fwd && dn_req_ready;
        live = dn_rsp_valid && (dn_rsp_port == ID_W'(PORT_ID));
        check_eq("R4", "dn_req_valid", 32'(dn_req_valid), 32'(fwd));
        check_eq("R2", "up_req_accept", 32'(up_req_accept), 32'(acc));
        if (fwd) begin
            check_eq("R2", "dn_req_data", 32'(dn_req_data), 32'(up_req_data));
            check_eq("R2", "dn_req_port", 32'(dn_req_port), PORT_ID);
        end
        check_eq("R5", "up_rsp_valid", 32'(up_rsp_valid), 32'(live || (m_full && up_rsp_resume)));
        if (m_full && up_rsp_resume)
            check_eq("R6", "up_rsp_data held", 32'(up_rsp_data), 32'(m_data));
        else if (live)
            check_eq("R5", "up_rsp_data live", 32'(up_rsp_data), 32'(dn_rsp_data));
        check_eq("R7", "up_retry", 32'(up_retry), 32'(m_retry));
        rel    = m_full && up_rsp_resume && up_rsp_ready;
        n_full = m_full;
        n_data = m_data;
        if (live && !m_full && !up_rsp_ready) begin n_full = 1; n_data = dn_rsp_data; end
        else if (rel) n_full = 0;
        wake    = res_free || rel;
        n_retry = m_owed && !n_full && wake;
        n_owed  = n_retry ? 1'b0 : (m_owed || (up_req_valid && !acc));
    endtask

    task automatic adv();
        @(posedge clk);
        m_owed = n_owed; m_full = n_full; m_data = n_data; m_retry = n_retry;
        #1;
    endtask

    task automatic idle();
        up_req_valid = 0; dn_req_ready = 0; dn_rsp_valid = 0; up_rsp_ready = 0;
        up_rsp_resume = 0; res_free = 0; dn_rsp_port = '0;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset
        repeat (2) @(posedge clk);
        #5;
        check_eq("R1", "up_retry", 32'(up_retry), 0);
        check_eq("R1", "up_rsp_valid", 32'(up_rsp_valid), 0);
        check_eq("R1", "dn_req_valid", 32'(dn_req_valid), 0);
        @(posedge clk); #1;
        rst_n = 1;

        // R2: plain forward
        up_req_valid = 1; up_req_data = 16'hA5A5; dn_req_ready = 1;
        settle();
        check_eq("R2", "accept", 32'(up_req_accept), 1);
        check_eq("R2", "port", 32'(dn_req_port), PORT_ID);
        adv();
        // R3: downstream refusal
        dn_req_ready = 0; settle();
        check_eq("R3", "refused", 32'(up_req_accept), 0);
        adv();
        dn_req_ready = 1; settle();
        check_eq("R3", "owed blocks forward", 32'(dn_req_valid), 0);
        adv();
        // R7: notice after res_free
        idle(); res_free = 1; settle(); adv();
        res_free = 0; up_req_valid = 1; dn_req_ready = 1; up_req_data = 16'h0F0F;
        settle();
        check_eq("R7", "notice pulse", 32'(up_retry), 1);
        check_eq("R10", "accept in notice cycle", 32'(up_req_accept), 1);
        adv();
        idle(); settle();
        check_eq("R7", "notice one cycle", 32'(up_retry), 0);
        adv();
        // R5: routing
        dn_rsp_valid = 1; dn_rsp_port = 2'd1; dn_rsp_data = 16'h7777; up_rsp_ready = 1;
        settle();
        check_eq("R5", "foreign response", 32'(up_rsp_valid), 0);
        adv();
        dn_rsp_port = 2'd2; dn_rsp_data = 16'h1234; settle();
        check_eq("R5", "own response data", 32'(up_rsp_data), 32'h1234);
        adv();
        // R6/R8: owed plus held response
        idle(); up_req_valid = 1; settle(); adv();
        idle(); dn_rsp_valid = 1; dn_rsp_port = 2'd2; dn_rsp_data = 16'hBEEF; settle(); adv();
        idle(); res_free = 1; up_req_valid = 1; dn_req_ready = 1; settle();
        check_eq("R4", "held blocks forward", 32'(dn_req_valid), 0);
        check_eq("R6", "held silent", 32'(up_rsp_valid), 0);
        adv();
        idle(); up_rsp_resume = 1; settle();
        check_eq("R8", "no notice while held", 32'(up_retry), 0);
        check_eq("R6", "held data", 32'(up_rsp_data), 32'hBEEF);
        adv();
        up_rsp_ready = 1; settle();
        check_eq("R6", "still held", 32'(up_rsp_valid), 1);
        adv();
        idle(); settle();
        check_eq("R8", "notice after drain", 32'(up_retry), 1);
        adv();
        // R9: no owed, no notice
        res_free = 1; settle(); adv();
        idle(); settle();
        check_eq("R9", "no notice", 32'(up_retry), 0);
        adv();

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            up_req_valid  = ($urandom % 2) == 0;
            up_req_data   = REQ_W'($urandom);
            dn_req_ready  = ($urandom % 4) != 0;
            up_rsp_ready  = ($urandom % 2) == 0;
            up_rsp_resume = ($urandom % 3) == 0;
            res_free      = ($urandom % 6) == 0;
            dn_rsp_data   = RSP_W'($urandom);
            dn_rsp_valid  = 0;
            dn_rsp_port   = 2'd0;
            if (!m_full && ($urandom % 4) == 0) begin
                dn_rsp_valid = 1; dn_rsp_port = 2'd2;
            end else if (($urandom % 6) == 0) begin
                dn_rsp_valid = 1; dn_rsp_port = 2'(($urandom % 2) * 3);
            end
            settle();
            adv();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule